// File: doc/BRIEF.md
# UART Transmit Byte Queue with Threshold Flags

This block holds the bytes that software has queued for a UART transmitter. A write strobe with a byte appends to the tail. The serial shifter takes bytes from the head with a pop strobe. It may only take a byte while the transmit-enable bit is high and the queue holds data. The block keeps an occupancy count and derives full and empty indications from that count. It also keeps a sticky threshold flag, which is set when the count climbs to a programmable level and cleared when draining takes the count below that level.

Two single-cycle event pulses feed the interrupt logic. One fires on each accepted write that leaves the count at or above the threshold. The other fires when the queue runs dry. A flush strobe comes from a control-register bit. It empties the queue in one cycle.

When the queue is full, a write is dropped silently. The exception is a write that arrives together with an effective pop, which is accepted. All outputs are registered state or decode that state directly. Every change is therefore visible one clock after the strobe that caused it.

Top module: `uart_txq`

## Requirements
- R1: After reset the level is 0, empty is 1, full is 0, the threshold flag is 0 and both event outputs are 0.
- R2: A write accepted while not full raises the level by one. Bytes leave the head in the order they were written.
- R3: A write while the level equals DEPTH, with no effective pop in the same cycle, is discarded. The level and the head byte stay unchanged.
- R4: A pop takes effect only while tx_en is 1 and the level is nonzero. Otherwise it changes nothing.
- R5: A write and an effective pop in the same cycle leave the level unchanged. Both are accepted, including when the queue is full.
- R6: full is 1 exactly when the level equals DEPTH. empty is 1 exactly when the level is 0.
- R7: An accepted write that leaves the level greater than or equal to the threshold sets the threshold flag. It also pulses wm_evt for one cycle, in the cycle the new level appears.
- R8: An effective pop without an accepted write, which leaves the level below the threshold, clears the threshold flag. Otherwise the flag holds its value.
- R9: empty_evt pulses for one cycle whenever the level goes from nonzero to zero, whether by pop or by flush.
- R10: A flush forces the level to 0 and clears the threshold flag. A write or pop in the same cycle is ignored. Afterwards the head shows the next byte written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe from the data register |
| wr_byte_i | input | DW | Byte to queue |
| rd_i | input | 1 | Pop request from the serial shifter |
| thresh_i | input | LVLW | Threshold level |
| flush_i | input | 1 | Synchronous queue clear |
| tx_en_i | input | 1 | Transmit enable; gates pops |
| head_o | output | DW | Oldest byte (valid while not empty) |
| level_o | output | LVLW | Number of bytes held |
| full_o | output | 1 | Level equals DEPTH |
| empty_o | output | 1 | Level is zero |
| wm_o | output | 1 | Sticky threshold flag |
| wm_evt_o | output | 1 | Threshold event pulse |
| empty_evt_o | output | 1 | Ran-dry event pulse |

## Verification
The bench builds the block with DEPTH=8, which gives a 4-bit level and 3-bit pointers. This keeps the full boundary a few writes away, so overflow, write-while-full-with-pop and pointer wrap all appear in short directed sequences. Thresholds of 0, 3, 5 and DEPTH are used. They cover a flag that any write sets, mid-range set and clear points, and a flag that only a completely full queue sets.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  // Next occupancy count after one cycle of queue traffic.
  function automatic int unsigned step_level(int unsigned lvl, logic inc, logic dec);
    return lvl + 32'(inc) - 32'(dec);
  endfunction

  // Threshold flag update: a write at/above the threshold sets it,
  // a drain-only cycle below the threshold clears it.
  function automatic logic next_wm(logic cur, logic wr_ok, logic rd_ok,
                                   int unsigned nlvl, int unsigned thr);
    if (wr_ok && nlvl >= thr) return 1'b1;
    if (rd_ok && !wr_ok && nlvl < thr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          clr,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  assign head = mem[rptr];

  a_r10_no_move_on_clr: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0 && rptr == '0));
endmodule

// File: rtl/uart_txq_level.sv
module uart_txq_level #(
  parameter int DEPTH = 32,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic            rd_req,
  input  logic            tx_en,
  input  logic            flush,
  output logic            wr_ok,
  output logic            rd_ok,
  output logic [LVLW-1:0] level_q,
  output logic [LVLW-1:0] level_n,
  output logic            full,
  output logic            empty
);
  import uart_txq_pkg::*;

  assign empty = (level_q == '0);
  assign full  = (level_q == LVLW'(DEPTH));
  assign rd_ok = rd_req && tx_en && !empty && !flush;
  assign wr_ok = wr_req && !flush && (!full || rd_ok);
  assign level_n = flush ? '0 : LVLW'(step_level(32'(level_q), wr_ok, rd_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_n;
  end

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVLW'(DEPTH));
  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req && !flush) |=> full);
  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !wr_req && !flush) |=> $stable(level_q));
  a_r5_swap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_ok) |=> $stable(level_q));
endmodule

// File: rtl/uart_txq_flags.sv
module uart_txq_flags #(
  parameter int LVLW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok,
  input  logic            rd_ok,
  input  logic            flush,
  input  logic [LVLW-1:0] level_q,
  input  logic [LVLW-1:0] level_n,
  input  logic [LVLW-1:0] thresh,
  output logic            wm,
  output logic            wm_evt,
  output logic            empty_evt
);
  import uart_txq_pkg::*;

  logic wm_set_evt, dry_evt;
  assign wm_set_evt = wr_ok && (level_n >= thresh);
  assign dry_evt    = (level_q != '0) && (level_n == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm        <= 1'b0;
      wm_evt    <= 1'b0;
      empty_evt <= 1'b0;
    end else begin
      wm        <= flush ? 1'b0
                         : next_wm(wm, wr_ok, rd_ok, 32'(level_n), 32'(thresh));
      wm_evt    <= wm_set_evt;
      empty_evt <= dry_evt;
    end
  end

  a_r7_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wm_evt |-> wm);
  a_r9_dry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |-> (level_q == '0));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    empty_evt |=> !empty_evt);
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!wm && level_q == '0));
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int LVLW = $clog2(DEPTH) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [DW-1:0]   wr_byte_i,
  input  logic            rd_i,
  input  logic [LVLW-1:0] thresh_i,
  input  logic            flush_i,
  input  logic            tx_en_i,
  output logic [DW-1:0]   head_o,
  output logic [LVLW-1:0] level_o,
  output logic            full_o,
  output logic            empty_o,
  output logic            wm_o,
  output logic            wm_evt_o,
  output logic            empty_evt_o
);
  logic            wr_ok, rd_ok;
  logic [LVLW-1:0] level_n;

  uart_txq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_i), .rd_req(rd_i), .tx_en(tx_en_i),
    .flush(flush_i), .wr_ok(wr_ok), .rd_ok(rd_ok), .level_q(level_o),
    .level_n(level_n), .full(full_o), .empty(empty_o)
  );

  uart_txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_data(wr_byte_i),
    .rd_en(rd_ok), .clr(flush_i), .head(head_o)
  );

  uart_txq_flags #(.LVLW(LVLW)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok), .flush(flush_i),
    .level_q(level_o), .level_n(level_n), .thresh(thresh_i),
    .wm(wm_o), .wm_evt(wm_evt_o), .empty_evt(empty_evt_o)
  );

  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));
  a_r2_write_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !rd_i && !flush_i && !full_o) |=> (level_o == $past(level_o) + 1'b1));
endmodule

// File: tb/tb_uart_txq.sv
`timescale 1ns/100ps
module tb_uart_txq;
  localparam int D = 8;
  localparam int LW = $clog2(D) + 1;

  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0, flush = 0, en = 0;
  logic [7:0] wb = 0;
  logic [LW-1:0] thr = 0;
  logic [7:0] head;
  logic [LW-1:0] level;
  logic full, empty, wm, wev, eev;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic m_wm = 0, m_wev = 0, m_eev = 0;

  always #2.5 clk = ~clk;

  uart_txq #(.DEPTH(D), .DW(8)) dut (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .wr_byte_i(wb), .rd_i(rd),
    .thresh_i(thr), .flush_i(flush), .tx_en_i(en), .head_o(head),
    .level_o(level), .full_o(full), .empty_o(empty), .wm_o(wm),
    .wm_evt_o(wev), .empty_evt_o(eev)
  );

  task automatic chk(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(level, q.size(), tag, "level");
    chk(empty, q.size() == 0, tag, "empty");
    chk(full, q.size() == D, tag, "full");
    chk(wm, m_wm, tag, "wm");
    chk(wev, m_wev, tag, "wm_evt");
    chk(eev, m_eev, tag, "empty_evt");
    if (q.size() != 0) chk(head, q[0], tag, "head");
  endtask

  // One clock of traffic: drive at negedge, update model, sample after posedge.
  task automatic cyc(bit w, logic [7:0] b, bit r, bit f, string tag);
    int was;
    bit pe, pa;
    @(negedge clk);
    wr = w; wb = b; rd = r; flush = f;
    was = q.size();
    pe = r && en && was > 0 && !f;
    pa = w && !f && (was < D || pe);
    if (f) begin
      q.delete(); m_wm = 0; m_wev = 0;
    end else begin
      if (pe) void'(q.pop_front());
      if (pa) q.push_back(b);
      m_wev = pa && q.size() >= thr;
      if (m_wev) m_wm = 1;
      else if (pe && !pa && q.size() < thr) m_wm = 0;
    end
    m_eev = was != 0 && q.size() == 0;
    @(posedge clk); #1;
    wr = 0; rd = 0; flush = 0;
    check_all(tag);
  endtask

  task automatic t_reset();
    check_all("R1");
    chk(empty, 1, "R6", "empty at reset");
  endtask

  task automatic t_fill_order();
    thr = 5; en = 0;
    for (int i = 0; i < D; i++) cyc(1, 8'h10 + 8'(i), 0, 0, i < 4 ? "R2" : "R7");
    chk(full, 1, "R6", "full at DEPTH");
    en = 1;
    cyc(0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, "R8");
    cyc(0, 0, 1, 0, "R8"); // level 5 -> stays set
    cyc(0, 0, 1, 0, "R8"); // level 4 < 5 -> clears
    chk(wm, 0, "R8", "flag cleared below threshold");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, "R9");
  endtask

  task automatic t_overflow();
    thr = LW'(D); en = 0;
    for (int i = 0; i < D; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, "R7");
    cyc(1, 8'hEE, 0, 0, "R3");
    cyc(1, 8'hEF, 1, 0, "R3"); // tx disabled: still dropped
    chk(head, 8'hA0, "R3", "head unchanged");
  endtask

  task automatic t_drain_gate();
    en = 0;
    cyc(0, 0, 1, 0, "R4");
    en = 1;
    cyc(1, 8'h55, 1, 0, "R5"); // full, swap accepted
    chk(level, D, "R5", "level held full");
    for (int i = 0; i < D; i++) cyc(0, 0, 1, 0, i == D - 1 ? "R9" : "R4");
    cyc(0, 0, 1, 0, "R4"); // pop on empty ignored
  endtask

  task automatic t_swap_wrap();
    thr = 3; en = 1;
    cyc(1, 8'h01, 0, 0, "R2");
    cyc(1, 8'h02, 0, 0, "R2");
    for (int i = 0; i < 12; i++) cyc(1, 8'h30 + 8'(i), 1, 0, "R5");
    cyc(1, 8'h77, 0, 0, "R7");
    chk(wev, 1, "R7", "event at threshold");
    cyc(0, 0, 1, 0, "R8");
    thr = 0;
    cyc(1, 8'h78, 0, 0, "R7");
  endtask

  task automatic t_flush();
    cyc(1, 8'h99, 0, 1, "R10");
    chk(level, 0, "R10", "level after flush");
    cyc(0, 0, 0, 1, "R10"); // flush while empty: no dry event
    cyc(1, 8'h42, 0, 0, "R10");
    chk(head, 8'h42, "R10", "head after flush");
    thr = 0;
    cyc(1, 8'h43, 1, 1, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_fill_order();
    t_overflow();
    t_drain_gate();
    t_swap_wrap();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule